// File: doc/BRIEF.md
# Windowed Command and Interrupt-Status Controller

This block is the host-facing control point of a network adapter. A small register bus writes 16-bit command words to one fixed offset. Each word holds a 5-bit opcode and an 11-bit argument. Reading the same offset returns a status word. That word holds the current register window, a command-busy flag and the latched interrupt causes as seen through a read mask. The window register chooses which of eight register pages the other offsets belong to. It is exported so that the page decoders beside this block can use it.

Six event inputs from the transmit, receive and statistics engines set cause bits. Software sets its own cause with a command and clears causes bit by bit with an acknowledge command. An unmasked pending cause sets an interrupt latch, which drives the interrupt pin. Engine-control commands leave as single-cycle strobes.

A small state machine tracks command execution. `ST_IDLE` accepts a command. `ST_HOLD1` is the single busy cycle after an ordinary command. `ST_HOLDN` holds the busy flag for `BUSY_CYC` cycles after a reset-type command. The transitions are:
- `ST_IDLE` to `ST_HOLD1` on an ordinary command.
- `ST_IDLE` to `ST_HOLDN` on a reset-type command.
- `ST_HOLD1` to `ST_IDLE` always.
- `ST_HOLDN` to `ST_IDLE` when its down-counter reaches zero.

Top module: `hcu_top`

## Requirements
- R1: A command is taken only when the bus writes offset 0xE while the block is not busy. The opcode sits in bits 15:11 and the argument in bits 10:0. Writes to any other offset change nothing.
- R2: Opcode 1 loads the window from argument bits 2:0 and ignores the higher argument bits. The window appears in status bits 15:13, on `win_sel`, and in bits 2:0 of a read at offset 0xF, whose other bits read 0.
- R3: Status bit 12 is the busy flag. It is 1 for exactly one cycle after an ordinary command. It is 1 for `BUSY_CYC` cycles after opcodes 0, 5 and 11. A command written while busy is dropped.
- R4: Cause bits are numbered as follows:
  - bit 1: adapter failure.
  - bit 2: TX complete.
  - bit 3: TX space available.
  - bit 4: RX complete.
  - bit 5: RX early.
  - bit 6: software request, set by opcode 12.
  - bit 7: statistics update.

  Each event pulse latches its bit.
- R5: Opcode 13 clears every cause bit whose argument bit (7:0) is 1. An event arriving in the same cycle as the acknowledge of its bit leaves that bit set.
- R6: Opcode 14 loads the interrupt mask from argument bits 7:0 (reset value 0). Cause bit 0, the latch, is set whenever a cause from bits 7:1 is both pending and enabled in the mask. The latch clears only through an acknowledge of bit 0. `irq` follows the latch.
- R7: Opcode 15 loads the read mask from argument bits 7:0 (reset value 0xFF). Status bits 7:0 show the causes ANDed with this mask.
- R8: Opcodes 0, 3, 4, 5, 9, 10 and 11 each raise one strobe for exactly the cycle after the command is taken:
  - 0: `chip_reset_p`.
  - 3: `rx_disable_p`.
  - 4: `rx_enable_p`.
  - 5: `rx_reset_p`.
  - 9: `tx_enable_p`.
  - 10: `tx_disable_p`.
  - 11: `tx_reset_p`.
- R9: Opcode 0 returns the window, both masks and all causes to their reset values.
- R10: After reset, status reads 0x0000, the window is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data: status at 0xE, window at 0xF, else 0 |
| ev_fail | input | 1 | Adapter failure event |
| ev_tx_done | input | 1 | Transmit complete event |
| ev_tx_space | input | 1 | Transmit space available event |
| ev_rx_done | input | 1 | Receive complete event |
| ev_rx_early | input | 1 | Receive early event |
| ev_stats | input | 1 | Statistics update event |
| irq | output | 1 | Interrupt request |
| win_sel | output | 3 | Current register window |
| chip_reset_p | output | 1 | Global reset strobe |
| rx_disable_p | output | 1 | RX disable strobe |
| rx_enable_p | output | 1 | RX enable strobe |
| rx_reset_p | output | 1 | RX reset strobe |
| tx_enable_p | output | 1 | TX enable strobe |
| tx_disable_p | output | 1 | TX disable strobe |
| tx_reset_p | output | 1 | TX reset strobe |

## Verification
A command taken at clock edge k updates the window, the masks, the causes, the busy flag and the strobes by the read after edge k. The latch and `irq` react one edge later, at k+1, because they are computed from the registered causes. Each table vector therefore waits two further edges before it samples status and `irq`. The strobe and busy checks sample right after edge k. The long-busy checks sample after edge k+`BUSY_CYC`-1, where the flag must still be 1, and after the next edge, where it must be 0. All samples are taken on the falling clock edge.

// File: rtl/hcu_pkg.sv
package hcu_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 5;
    localparam int ARG_W  = WORD_W - OP_W;
    localparam int CAUSE_W = 8;
    localparam int STRB_W = 7;

    localparam logic [OP_W-1:0] OP_GRESET = 5'd0;
    localparam logic [OP_W-1:0] OP_WINDOW = 5'd1;
    localparam logic [OP_W-1:0] OP_RX_OFF = 5'd3;
    localparam logic [OP_W-1:0] OP_RX_ON  = 5'd4;
    localparam logic [OP_W-1:0] OP_RX_RST = 5'd5;
    localparam logic [OP_W-1:0] OP_TX_ON  = 5'd9;
    localparam logic [OP_W-1:0] OP_TX_OFF = 5'd10;
    localparam logic [OP_W-1:0] OP_TX_RST = 5'd11;
    localparam logic [OP_W-1:0] OP_SWREQ  = 5'd12;
    localparam logic [OP_W-1:0] OP_ACK    = 5'd13;
    localparam logic [OP_W-1:0] OP_IMASK  = 5'd14;
    localparam logic [OP_W-1:0] OP_RMASK  = 5'd15;

    // strobe vector positions
    localparam int SB_CHIP = 0;
    localparam int SB_RXOFF = 1;
    localparam int SB_RXON = 2;
    localparam int SB_RXRST = 3;
    localparam int SB_TXON = 4;
    localparam int SB_TXOFF = 5;
    localparam int SB_TXRST = 6;

    typedef struct packed {
        logic              win_ld;
        logic              ack;
        logic              imask_ld;
        logic              rmask_ld;
        logic              swreq;
        logic              greset;
        logic              long_busy;
        logic [STRB_W-1:0] strobe;
    } cmd_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLDN = 2'd2
    } busy_st_e;
endpackage

// File: rtl/hcu_decode.sv
module hcu_decode
    import hcu_pkg::*;
(
    input  logic              take,
    input  logic [OP_W-1:0]   opcode,
    output cmd_dec_t          dec
);
    always_comb begin
        dec = '0;
        if (take) begin
            unique case (opcode)
                OP_GRESET: begin
                    dec.greset = 1'b1;
                    dec.long_busy = 1'b1;
                    dec.strobe[SB_CHIP] = 1'b1;
                end
                OP_WINDOW: dec.win_ld = 1'b1;
                OP_RX_OFF: dec.strobe[SB_RXOFF] = 1'b1;
                OP_RX_ON:  dec.strobe[SB_RXON] = 1'b1;
                OP_RX_RST: begin
                    dec.long_busy = 1'b1;
                    dec.strobe[SB_RXRST] = 1'b1;
                end
                OP_TX_ON:  dec.strobe[SB_TXON] = 1'b1;
                OP_TX_OFF: dec.strobe[SB_TXOFF] = 1'b1;
                OP_TX_RST: begin
                    dec.long_busy = 1'b1;
                    dec.strobe[SB_TXRST] = 1'b1;
                end
                OP_SWREQ:  dec.swreq = 1'b1;
                OP_ACK:    dec.ack = 1'b1;
                OP_IMASK:  dec.imask_ld = 1'b1;
                OP_RMASK:  dec.rmask_ld = 1'b1;
                default:   dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/hcu_busy_fsm.sv
module hcu_busy_fsm
    import hcu_pkg::*;
#(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic long_req,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

    busy_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        busy  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (take && long_req) begin
                    st_d  = ST_HOLDN;
                    cnt_d = CNT_LOAD;
                end else if (take) begin
                    st_d = ST_HOLD1;
                end
            end
            ST_HOLD1: begin
                busy = 1'b1;
                st_d = ST_IDLE;
            end
            ST_HOLDN: begin
                busy = 1'b1;
                if (cnt_q == '0) st_d = ST_IDLE;
                else cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    a_r3_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);
    a_r3_long_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLDN && cnt_q != '0) |=> busy);
    a_r3_short_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD1) |=> !busy);
endmodule

// File: rtl/hcu_cause_bank.sv
module hcu_cause_bank
    import hcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev_set,
    input  logic               ack_vld,
    input  logic               imask_ld,
    input  logic               rmask_ld,
    input  logic               greset,
    input  logic [CAUSE_W-1:0] arg_bits,
    output logic [CAUSE_W-1:0] cause_vis,
    output logic               irq
);
    logic [CAUSE_W-1:1] cause_q;
    logic               latch_q;
    logic [CAUSE_W-1:0] imask_q, rmask_q;
    logic [CAUSE_W-1:0] ack_bits;
    logic               pending;

    assign ack_bits = ack_vld ? arg_bits : '0;
    assign pending  = |(cause_q & imask_q[CAUSE_W-1:1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            latch_q <= 1'b0;
            imask_q <= '0;
            rmask_q <= '1;
        end else if (greset) begin
            cause_q <= '0;
            latch_q <= 1'b0;
            imask_q <= '0;
            rmask_q <= '1;
        end else begin
            cause_q <= (cause_q & ~ack_bits[CAUSE_W-1:1]) | ev_set[CAUSE_W-1:1];
            latch_q <= pending | (latch_q & ~ack_bits[0]);
            if (imask_ld) imask_q <= arg_bits;
            if (rmask_ld) rmask_q <= arg_bits;
        end
    end

    assign cause_vis = {cause_q, latch_q} & rmask_q;
    assign irq = latch_q;

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !greset) |=>
        ((cause_q & $past(arg_bits[CAUSE_W-1:1] & ~ev_set[CAUSE_W-1:1])) == '0));
    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_set) && !greset) |=>
        ((cause_q & $past(ev_set[CAUSE_W-1:1])) == $past(ev_set[CAUSE_W-1:1])));
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !(ack_vld && arg_bits[0]) && !greset) |=> irq);
endmodule

// File: rtl/hcu_top.sv
module hcu_top
    import hcu_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int WIN_W    = 3,
    parameter int BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              ev_fail,
    input  logic              ev_tx_done,
    input  logic              ev_tx_space,
    input  logic              ev_rx_done,
    input  logic              ev_rx_early,
    input  logic              ev_stats,
    output logic              irq,
    output logic [WIN_W-1:0]  win_sel,
    output logic              chip_reset_p,
    output logic              rx_disable_p,
    output logic              rx_enable_p,
    output logic              rx_reset_p,
    output logic              tx_enable_p,
    output logic              tx_disable_p,
    output logic              tx_reset_p
);
    localparam logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(4'hE);
    localparam logic [ADDR_W-1:0] WIN_OFS = ADDR_W'(4'hF);
    localparam int PAD_W = WORD_W - WIN_W - 1 - CAUSE_W;

    logic               busy, take;
    cmd_dec_t           dec;
    logic [WIN_W-1:0]   win_q;
    logic [STRB_W-1:0]  strb_q;
    logic [CAUSE_W-1:0] ev_set, cause_vis;
    logic [WORD_W-1:0]  status;

    assign take = bus_wr && (bus_addr == CMD_OFS) && !busy;

    hcu_decode u_dec (
        .take   (take),
        .opcode (bus_wdata[WORD_W-1:ARG_W]),
        .dec    (dec)
    );

    hcu_busy_fsm #(.BUSY_CYC(BUSY_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .long_req (dec.long_busy),
        .busy     (busy)
    );

    assign ev_set = {ev_stats, dec.swreq, ev_rx_early, ev_rx_done,
                     ev_tx_space, ev_tx_done, ev_fail, 1'b0};

    hcu_cause_bank u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_set    (ev_set),
        .ack_vld   (dec.ack),
        .imask_ld  (dec.imask_ld),
        .rmask_ld  (dec.rmask_ld),
        .greset    (dec.greset),
        .arg_bits  (bus_wdata[CAUSE_W-1:0]),
        .cause_vis (cause_vis),
        .irq       (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= '0;
            strb_q <= '0;
        end else begin
            strb_q <= dec.strobe;
            if (dec.greset) win_q <= '0;
            else if (dec.win_ld) win_q <= bus_wdata[WIN_W-1:0];
        end
    end

    assign status = {win_q, busy, {PAD_W{1'b0}}, cause_vis};

    always_comb begin
        if (bus_addr == CMD_OFS) bus_rdata = status;
        else if (bus_addr == WIN_OFS) bus_rdata = {{(WORD_W-WIN_W){1'b0}}, win_q};
        else bus_rdata = '0;
    end

    assign win_sel      = win_q;
    assign chip_reset_p = strb_q[SB_CHIP];
    assign rx_disable_p = strb_q[SB_RXOFF];
    assign rx_enable_p  = strb_q[SB_RXON];
    assign rx_reset_p   = strb_q[SB_RXRST];
    assign tx_enable_p  = strb_q[SB_TXON];
    assign tx_disable_p = strb_q[SB_TXOFF];
    assign tx_reset_p   = strb_q[SB_TXRST];

    a_r2_window_load: assert property (@(posedge clk) disable iff (!rst_n)
        (take && dec.win_ld) |=> (win_sel == $past(bus_wdata[WIN_W-1:0])));
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chip_reset_p, rx_disable_p, rx_enable_p, rx_reset_p,
                  tx_enable_p, tx_disable_p, tx_reset_p}));
    a_r1_other_offset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != CMD_OFS) |=> (win_sel == $past(win_sel)));
endmodule

// File: tb/sim_hcu_top.sv
module sim_hcu_top;
    localparam int BUSY_CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  ev = 8'h0;
    logic        irq;
    logic [2:0]  win_sel;
    logic        chip_reset_p, rx_disable_p, rx_enable_p, rx_reset_p;
    logic        tx_enable_p, tx_disable_p, tx_reset_p;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    hcu_top #(.BUSY_CYC(BUSY_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_fail(ev[1]), .ev_tx_done(ev[2]), .ev_tx_space(ev[3]),
        .ev_rx_done(ev[4]), .ev_rx_early(ev[5]), .ev_stats(ev[7]),
        .irq(irq), .win_sel(win_sel), .chip_reset_p(chip_reset_p),
        .rx_disable_p(rx_disable_p), .rx_enable_p(rx_enable_p),
        .rx_reset_p(rx_reset_p), .tx_enable_p(tx_enable_p),
        .tx_disable_p(tx_disable_p), .tx_reset_p(tx_reset_p)
    );

    // {offset, write word, events, expected status}
    localparam int NV = 12;
    localparam logic [43:0] VEC [NV] = '{
        {4'hE, 16'h0803, 8'h00, 16'h6000}, // R2 window 3
        {4'h0, 16'h0806, 8'h04, 16'h6004}, // R1 other offset ignored, R4 tx done
        {4'hE, 16'h7004, 8'h00, 16'h6005}, // R6 mask bit2 -> latch
        {4'hE, 16'h6804, 8'h00, 16'h6001}, // R5 ack bit2, R6 latch held
        {4'hE, 16'h6801, 8'h00, 16'h6000}, // R6 ack latch
        {4'hE, 16'h6000, 8'h00, 16'h6040}, // R4 software request
        {4'hE, 16'h6850, 8'h10, 16'h6010}, // R5 event wins over ack
        {4'hE, 16'h7801, 8'h00, 16'h6000}, // R7 read mask hides
        {4'hE, 16'h78FF, 8'h00, 16'h6010}, // R7 read mask all
        {4'hE, 16'h7010, 8'h00, 16'h6011}, // R6 mask bit4
        {4'hE, 16'h0FFD, 8'h00, 16'hA011}, // R2 high arg bits ignored
        {4'h2, 16'h0000, 8'h82, 16'hA093}  // R4 fail + stats
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] strobes();
        return {9'b0, tx_reset_p, tx_disable_p, tx_enable_p, rx_reset_p,
                rx_enable_p, rx_disable_p, chip_reset_p};
    endfunction

    task automatic wr_cmd(input logic [15:0] w);
        @(negedge clk);
        bus_addr = 4'hE; bus_wr = 1'b1; bus_wdata = w;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!finished && $time > 1500000) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_addr = 4'hE;
        #1;
        check("R10 status", bus_rdata, 16'h0000);
        check("R10 irq", {15'b0, irq}, 16'h0);
        check("R10 window", {13'b0, win_sel}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr = VEC[i][43:40]; bus_wdata = VEC[i][39:24];
            ev = VEC[i][23:16]; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0; ev = 8'h0; bus_addr = 4'hE;
            repeat (2) @(negedge clk);
            #1;
            check($sformatf("R4/R5/R6/R7 vector %0d status", i), bus_rdata, VEC[i][15:0]);
            check($sformatf("R6 vector %0d irq", i), {15'b0, irq}, {15'b0, VEC[i][0]});
        end

        // R2 window at offset 0xF and on the port
        bus_addr = 4'hF; #1;
        check("R2 offset F", bus_rdata, 16'h0005);
        check("R2 win_sel", {13'b0, win_sel}, 16'h0005);

        // R3/R8 short busy with tx enable strobe
        wr_cmd(16'h4800);
        bus_addr = 4'hE; #1;
        check("R3 short busy set", {15'b0, bus_rdata[12]}, 16'h1);
        check("R8 tx enable strobe", strobes(), 16'h0010);
        @(negedge clk); #1;
        check("R3 short busy clear", {15'b0, bus_rdata[12]}, 16'h0);
        check("R8 strobe one cycle", strobes(), 16'h0000);

        // R3 long busy after rx reset, command during busy dropped
        wr_cmd(16'h2800);
        #1;
        check("R8 rx reset strobe", strobes(), 16'h0008);
        check("R3 long busy set", {15'b0, bus_rdata[12]}, 16'h1);
        bus_addr = 4'hE; bus_wr = 1'b1; bus_wdata = 16'h0806;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (BUSY_CYC - 2) @(negedge clk);
        #1;
        check("R3 long busy last cycle", {15'b0, bus_rdata[12]}, 16'h1);
        @(negedge clk); #1;
        check("R3 long busy clear", {15'b0, bus_rdata[12]}, 16'h0);
        check("R3 dropped command", {13'b0, win_sel}, 16'h0005);

        // R9 global reset
        wr_cmd(16'h0000);
        #1;
        check("R8 chip reset strobe", strobes(), 16'h0001);
        repeat (BUSY_CYC) @(negedge clk);
        #1;
        check("R9 status cleared", bus_rdata, 16'h0000);
        check("R9 irq cleared", {15'b0, irq}, 16'h0);
        check("R9 window cleared", {13'b0, win_sel}, 16'h0);

        // R6 interrupt mask reset to 0 after global reset
        @(negedge clk);
        ev = 8'h08;
        @(negedge clk);
        ev = 8'h00;
        repeat (2) @(negedge clk);
        #1;
        check("R9 masks restored", bus_rdata, 16'h0008);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule